// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits at the front of a controller for a two-bank single-data-rate SDRAM and owns the command bus whenever the device is not in user hands. When reset is released, it brings the device up in a fixed order. First it waits with the command bus idle and the clock enable high. Then it precharges all banks, issues a programmable number of auto-refresh commands and writes the mode register. After that it raises `ready` so the user side may start work.

During normal operation an interval timer raises `refresh_pending` at a fixed cadence, and `ready` drops at the same time. The user side signals through `user_busy` that its access is still open. Refresh has priority: it is issued as soon as `user_busy` is low. While `user_busy` stays high the request is held. All waits are written in nanoseconds and converted to cycle counts at elaboration from the clock period parameter. Device waits round up, with a floor of two cycles. The refresh interval rounds down so that the average never exceeds the requirement.

Top module: `sdram_pwrup_refresh`

## Requirements
- R1: While `rst_n` is low, `cke` is low, the command bus shows NOP ({cs_n,ras_n,cas_n,we_n} = 0111), and `ready` and `refresh_pending` are low.
- R2: After reset is released, `cke` is high and the bus shows NOP for exactly ceil(POWERUP_NS / clock period) cycles before the first command; the deassertion cycle counts as the first of them.
- R3: The first command is precharge-all: the bus shows 0010 with address bit 10 high and every other address bit low.
- R4: INIT_REFS auto-refresh commands (0001) follow. The first comes TRP cycles after the precharge and each later one TRC cycles after the previous one. TRP and TRC are ceil(ns / period) with a minimum of 2. No command is ever directly followed by another command in the next cycle.
- R5: TRC cycles after the last initial refresh, a mode register write (0000) is issued with bank address 0. Address bits 2:0 carry the burst code (length 1→0, 2→1, 4→2, 8→3, full page (BURST_LEN=0)→7). Bit 3 carries the ordering (1 = interleaved). Bits 6:4 carry the CAS latency. Bits 11:7 are zero.
- R6: `ready` rises TMRD cycles after the mode register write (TMRD is the cycle parameter, minimum 2).
- R7: Counting from the first cycle `ready` is high, `refresh_pending` rises every floor(REFI_NS / period) cycles. `ready` is low in every cycle in which `refresh_pending` is high.
- R8: With `user_busy` low, an auto-refresh is issued in the cycle after `refresh_pending` rises. `refresh_pending` falls the cycle after that refresh, and `ready` returns TRC cycles after the refresh.
- R9: While `user_busy` is high, a pending refresh is held: no command is issued and `ready` stays low. The refresh is issued in the first cycle in which `user_busy` is seen low, and the schedule of later requests does not shift.
- R10: While `ready` is high the bus shows only NOP.
- R11: `user_busy` has no effect on the initialization sequence or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| user_busy | input | 1 | High while a user access holds banks open |
| ready | output | 1 | Device initialized and no refresh due or running |
| refresh_pending | output | 1 | A refresh is due and not yet issued |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 12 | Address bus |

## Verification
The hardest situation to reach is a refresh request that lands while the user side holds `user_busy` high and keeps it high for many cycles. In that case the request has to wait without shifting the later refresh cadence. The stimulus drives `user_busy` high a few cycles before the third periodic expiry and holds it twenty cycles past that expiry. The command, `ready` and `refresh_pending` are then compared in every cycle against a schedule the bench computes from the cycle counts. `user_busy` is also driven high through most of initialization to show that it is ignored there. A second instance at a slower clock period, with a different latency, burst length and ordering, checks the mode word and the timing conversion.

// File: rtl/sdram_pwrup_refresh.sv
module sdram_pwrup_refresh #(
  parameter int CLK_PS     = 8000,
  parameter int CAS_LAT    = 3,
  parameter int BURST_LEN  = 8,
  parameter int BURST_ILV  = 0,
  parameter int POWERUP_NS = 200000,
  parameter int TRP_NS     = 20,
  parameter int TRC_NS     = 70,
  parameter int TMRD_CYC   = 3,
  parameter int REFI_NS    = 15600,
  parameter int INIT_REFS  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        user_busy,
  output logic        ready,
  output logic        refresh_pending,
  output logic        cke,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [1:0]  ba,
  output logic [11:0] addr
);
  localparam int PU_RAW   = (POWERUP_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int PU_CYC   = (PU_RAW < 1) ? 1 : PU_RAW;
  localparam int TRP_RAW  = (TRP_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int TRP_CYC  = (TRP_RAW < 2) ? 2 : TRP_RAW;
  localparam int TRC_RAW  = (TRC_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int TRC_CYC  = (TRC_RAW < 2) ? 2 : TRC_RAW;
  localparam int TMRD_W   = (TMRD_CYC < 2) ? 2 : TMRD_CYC;
  localparam int REFI_RAW = (REFI_NS * 1000) / CLK_PS;
  localparam int REFI_CYC = (REFI_RAW < 2) ? 2 : REFI_RAW;

  localparam logic [2:0] BL_CODE = (BURST_LEN == 0) ? 3'd7 :
                                   (BURST_LEN == 1) ? 3'd0 :
                                   (BURST_LEN == 2) ? 3'd1 :
                                   (BURST_LEN == 4) ? 3'd2 : 3'd3;
  localparam logic [11:0] MODE_WORD = {5'b0, 3'(CAS_LAT), 1'(BURST_ILV), BL_CODE};

  typedef enum logic [2:0] {
    S_PWR, S_PRE, S_PWAIT, S_REF, S_RWAIT, S_MRS, S_MWAIT, S_IDLE
  } st_t;

  st_t         st;
  logic [31:0] cnt, tmr, nref;
  logic        in_op, pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_PWR;
      cnt   <= 32'(PU_CYC - 1);
      nref  <= '0;
      in_op <= 1'b0;
      cke   <= 1'b0;
    end else begin
      cke <= 1'b1;
      case (st)
        S_PWR:   if (cnt == 0) st <= S_PRE; else cnt <= cnt - 1;
        S_PRE:   begin st <= S_PWAIT; cnt <= 32'(TRP_CYC - 2); nref <= '0; end
        S_PWAIT: if (cnt == 0) st <= S_REF; else cnt <= cnt - 1;
        S_REF:   begin st <= S_RWAIT; cnt <= 32'(TRC_CYC - 2); nref <= nref + 1; end
        S_RWAIT:
          if (cnt != 0)                    cnt <= cnt - 1;
          else if (in_op)                  st <= S_IDLE;
          else if (nref == 32'(INIT_REFS)) st <= S_MRS;
          else                             st <= S_REF;
        S_MRS:   begin st <= S_MWAIT; cnt <= 32'(TMRD_W - 2); end
        S_MWAIT:
          if (cnt == 0) begin st <= S_IDLE; in_op <= 1'b1; end
          else cnt <= cnt - 1;
        S_IDLE:  if (pend && !user_busy) st <= S_REF;
        default: st <= S_PWR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr  <= 32'(REFI_CYC - 1);
      pend <= 1'b0;
    end else if (in_op) begin
      if (st == S_REF) pend <= 1'b0;
      if (tmr == 0) begin
        tmr  <= 32'(REFI_CYC - 1);
        pend <= 1'b1;
      end else begin
        tmr <= tmr - 1;
      end
    end
  end

  always_comb begin
    {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    addr = '0;
    case (st)
      S_PRE: begin {cs_n, ras_n, cas_n, we_n} = 4'b0010; addr[10] = 1'b1; end
      S_REF: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      S_MRS: begin {cs_n, ras_n, cas_n, we_n} = 4'b0000; addr = MODE_WORD; end
      default: ;
    endcase
  end

  assign ba              = 2'b00;
  assign ready           = (st == S_IDLE) && !pend;
  assign refresh_pending = pend;
endmodule

// File: rtl/sdram_pwrup_refresh_chk.sv
module sdram_pwrup_refresh_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        user_busy,
  input logic        ready,
  input logic        refresh_pending,
  input logic        cke,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic [1:0]  ba,
  input logic [11:0] addr
);
  logic [3:0] cmd;
  assign cmd = {cs_n, ras_n, cas_n, we_n};

  p_cke_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cke);

  p_pre_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010) |-> addr[10]);

  p_cmd_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 4'b0111) |=> (cmd == 4'b0111));

  p_mrs_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0000) |-> (addr[11:7] == 5'b0 && ba == 2'b00));

  p_pending_blocks_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_pending |-> !ready);

  p_busy_defers_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0001 && $past(refresh_pending)) |-> !$past(user_busy));

  p_ready_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cmd == 4'b0111));
endmodule

bind sdram_pwrup_refresh sdram_pwrup_refresh_chk u_chk (.*);

// File: tb/tb_sdram_pwrup_refresh.sv
module tb_sdram_pwrup_refresh;
  localparam int PS = 8000, PS_B = 12000, PU_NS = 800, RI_NS = 1200;

  function automatic int cdiv(int a, int b); return (a + b - 1) / b; endfunction
  function automatic int lo2(int v); return (v < 2) ? 2 : v; endfunction

  localparam int P    = cdiv(PU_NS * 1000, PS) - 1;
  localparam int TRP  = lo2(cdiv(20000, PS));
  localparam int TRC  = lo2(cdiv(70000, PS));
  localparam int M    = P + TRP + 8 * TRC;
  localparam int I    = M + 3;
  localparam int REFI = (RI_NS * 1000) / PS;
  localparam int B    = I + 3 * REFI + 20;
  localparam int LAST = I + 4 * REFI + TRC + 5;
  localparam int PB   = cdiv(PU_NS * 1000, PS_B) - 1;
  localparam int MB   = PB + lo2(cdiv(20000, PS_B)) + 8 * lo2(cdiv(70000, PS_B));

  logic clk = 0, rst_n = 0, busy = 0;
  logic ready, pend, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [11:0] addr;
  logic ready_b, pend_b, cke_b, cs_b, ras_b, cas_b, we_b;
  logic [1:0] ba_b;
  logic [11:0] addr_b;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_pwrup_refresh #(.CLK_PS(PS), .CAS_LAT(3), .BURST_LEN(8), .BURST_ILV(0),
    .POWERUP_NS(PU_NS), .REFI_NS(RI_NS)) dut (
    .clk(clk), .rst_n(rst_n), .user_busy(busy), .ready(ready), .refresh_pending(pend),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr));

  sdram_pwrup_refresh #(.CLK_PS(PS_B), .CAS_LAT(2), .BURST_LEN(0), .BURST_ILV(1),
    .POWERUP_NS(PU_NS), .REFI_NS(RI_NS)) dut_b (
    .clk(clk), .rst_n(rst_n), .user_busy(1'b0), .ready(ready_b), .refresh_pending(pend_b),
    .cke(cke_b), .cs_n(cs_b), .ras_n(ras_b), .cas_n(cas_b), .we_n(we_b), .ba(ba_b), .addr(addr_b));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, int idx);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", req, idx, act, exp);
    end
  endtask

  function automatic int ref_at(int k); return (k == 3) ? B + 1 : I + k * REFI + 1; endfunction

  function automatic logic [3:0] exp_cmd(int i);
    if (i == P) return 4'b0010;
    for (int k = 0; k < 8; k++) if (i == P + TRP + k * TRC) return 4'b0001;
    if (i == M) return 4'b0000;
    for (int k = 1; k <= 4; k++) if (i == ref_at(k)) return 4'b0001;
    return 4'b0111;
  endfunction

  function automatic logic exp_pend(int i);
    for (int k = 1; k <= 4; k++) if (i >= I + k * REFI && i <= ref_at(k)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic exp_ready(int i);
    if (i < I) return 1'b0;
    for (int k = 1; k <= 4; k++) if (i >= I + k * REFI && i < ref_at(k) + TRC) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic busy_at(int j);
    return (j >= 11 && j <= P + 20) || (j >= I + 3 * REFI - 4 && j <= B);
  endfunction

  initial begin
    repeat (4) begin
      @(negedge clk);
      check("R1 cke", 32'(cke), 0, -1);
      check("R1 cmd", 32'({cs_n, ras_n, cas_n, we_n}), 32'h7, -1);
      check("R1 ready/pending", 32'({ready, pend}), 0, -1);
    end
    rst_n = 1;
    for (int i = 0; i <= LAST; i++) begin
      @(negedge clk);
      check("R2 cke high", 32'(cke), 1, i);
      // R3 R4 R5 R8 R9 R10 R11: full command schedule, busy toggled during init and around refresh 3
      check("R4/R8/R9 cmd", 32'({cs_n, ras_n, cas_n, we_n}), 32'(exp_cmd(i)), i);
      check("R6/R7/R9 ready", 32'(ready), 32'(exp_ready(i)), i);
      check("R7/R8 pending", 32'(pend), 32'(exp_pend(i)), i);
      if (i == P) check("R3 precharge addr", 32'(addr), 32'h400, i);
      if (i == M) check("R5 mode word", 32'({ba, addr}), 32'h033, i);
      if (i == MB) begin
        check("R5 mode cmd b", 32'({cs_b, ras_b, cas_b, we_b}), 0, i);
        check("R5 mode word b", 32'({ba_b, addr_b}), 32'h02F, i);
      end
      if (i == PB) check("R2 powerup b", 32'({cs_b, ras_b, cas_b, we_b}), 32'h2, i);
      if (i == PB - 1) check("R2 nop b", 32'({cs_b, ras_b, cas_b, we_b}), 32'h7, i);
      if (i == MB + 2) check("R6 ready b early", 32'(ready_b), 0, i);
      if (i == MB + 3) check("R6 ready b", 32'(ready_b), 1, i);
      busy = busy_at(i + 1);
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule